// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block drives the stack for subroutine calls, returns, interrupt entry and interrupt return in a small processor core. It holds a stack pointer into a byte-wide synchronous RAM. The RAM returns read data one cycle after the read address is presented. The block steps through the RAM cycles each transfer needs, one byte per cycle. When a transfer finishes, it hands the core a new program counter. It also owns the global interrupt-enable bit.

The stack grows downward. The stack pointer always addresses the next free byte. A push writes at the pointer and then decrements it. A pop first increments the pointer and then reads.

- A call stores the return address with its upper byte at the higher address, then jumps to the call target. A plain return reads both bytes back.
- Interrupt entry waits for an instruction boundary and for the enable bit. It stores the upper byte of the program counter, then the lower byte, then the status byte. It clears the enable bit and jumps to the vector.
- Interrupt return restores the status byte, then the lower byte, then the upper byte, and sets the enable bit again.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, `busy`, `ram_we`, `ram_re`, `pc_load` and `status_load` are 0, `gie` is 1, and the stack pointer is 0x8FF, so the first push writes address 0x8FF.
- R2: A call accepted while idle writes `pc_in[15:8]` at SP in the first busy cycle. In the second busy cycle it writes `pc_in[7:0]` at SP-1 with `pc_load`=1 and `pc_out` equal to the call target. The stack pointer drops by 2.
- R3: A plain return reads SP+1 (lower byte) and then SP+2 (upper byte) in its first two busy cycles. In the third busy cycle `pc_load`=1 and `pc_out` is {upper, lower}. The stack pointer rises by 2.
- R4: An interrupt request is taken only when all of these hold: `instr_done`=1, `gie`=1, the block is idle, and no call, return or interrupt-return request is present. Otherwise the block stays idle.
- R5: Interrupt entry clears `gie` from the first busy cycle. It writes `pc_in[15:8]` at SP, then `pc_in[7:0]` at SP-1, then `status_in` at SP-2. In that third cycle `pc_load`=1 and `pc_out` is the vector. The stack pointer drops by 3.
- R6: Interrupt return reads SP+1, SP+2 and SP+3 in its first three busy cycles. In the second cycle `status_load`=1 and `status_out` is the byte from SP+1. In the fourth cycle `pc_load`=1 with `pc_out` = {byte at SP+3, byte at SP+2}. `gie` is 1 from the next cycle, and the stack pointer rises by 3.
- R7: While `busy` is 1, new call, return, interrupt-return and interrupt requests are ignored. A RAM write and a RAM read never happen in the same cycle.
- R8: When requests arrive together at an idle block, a call wins over a return, a return over an interrupt return, and all three over an interrupt.
- R9: Nested calls push at strictly descending addresses and unwind in reverse. After balanced calls and returns, the next push writes the same address as before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_done | input | 1 | Current instruction completes this cycle |
| irq_pending | input | 1 | An interrupt request is waiting |
| irq_vector | input | 16 | Handler address for the pending interrupt |
| call_req | input | 1 | Call instruction requests a push and jump |
| call_target | input | 16 | Destination of the call |
| ret_req | input | 1 | Plain return request |
| reti_req | input | 1 | Return-from-interrupt request |
| pc_in | input | 16 | Address to be saved (return or resume address) |
| status_in | input | 8 | Status byte saved on interrupt entry |
| ram_we | output | 1 | Stack RAM write strobe |
| ram_re | output | 1 | Stack RAM read strobe |
| ram_addr | output | 12 | Stack RAM byte address |
| ram_wdata | output | 8 | Stack RAM write data |
| ram_rdata | input | 8 | Stack RAM read data, one cycle after `ram_re` |
| pc_load | output | 1 | Load `pc_out` into the program counter |
| pc_out | output | 16 | New program counter value |
| status_load | output | 1 | Load `status_out` into the status register |
| status_out | output | 8 | Restored status byte |
| gie | output | 1 | Global interrupt enable |
| busy | output | 1 | A stack sequence is in progress |

## Verification
The hardest case to reach is interrupt return after deep nesting. Pops must pick up bytes that were written by a mix of call pushes and interrupt pushes, at addresses that depend on everything pushed before. The stimulus builds this state on purpose. It walks a table of four nested calls and unwinds them, leaving the pointer back at its start. It then enters an interrupt, offers a second interrupt while the enable bit is clear, and returns from the handler with a bench RAM model. Last come simultaneous and mid-sequence requests, which test the precedence order and the ignore-while-busy rule.

// File: rtl/stkseq_pkg.sv
package stkseq_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PUSH_HI,
      ST_PUSH_LO,
      ST_PUSH_STAT,
      ST_POP_STAT,
      ST_POP_LO,
      ST_POP_HI,
      ST_POP_END
   } seq_state_t;

   function automatic logic is_push(input seq_state_t s);
      return (s == ST_PUSH_HI) || (s == ST_PUSH_LO) || (s == ST_PUSH_STAT);
   endfunction

   function automatic logic is_pop_read(input seq_state_t s);
      return (s == ST_POP_STAT) || (s == ST_POP_LO) || (s == ST_POP_HI);
   endfunction

endpackage

// File: rtl/stkseq_sp.sv
module stkseq_sp #(
   parameter int unsigned ADDR_W = 12,
   parameter logic [ADDR_W-1:0] SP_RESET = 12'h8FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dec,
   input  logic              inc,
   output logic [ADDR_W-1:0] sp,
   output logic [ADDR_W-1:0] sp_next_up
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp <= SP_RESET;
      end else if (dec) begin
         sp <= sp - 1'b1;
      end else if (inc) begin
         sp <= sp + 1'b1;
      end
   end

   assign sp_next_up = sp + 1'b1;

endmodule

// File: rtl/stkseq_fsm.sv
module stkseq_fsm
   import stkseq_pkg::*;
#(
   parameter logic GIE_RESET = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       instr_done,
   input  logic       irq_pending,
   input  logic       call_req,
   input  logic       ret_req,
   input  logic       reti_req,
   output seq_state_t state,
   output logic       framed,
   output logic       take_any,
   output logic       take_irq,
   output logic       gie
);

   logic       idle;
   logic       take_call, take_ret, take_reti;
   logic       framed_q, gie_q;
   seq_state_t state_q, state_d;

   assign idle      = (state_q == ST_IDLE);
   assign take_call = idle & call_req;
   assign take_ret  = idle & ~call_req & ret_req;
   assign take_reti = idle & ~call_req & ~ret_req & reti_req;
   assign take_irq  = idle & ~call_req & ~ret_req & ~reti_req
                      & irq_pending & instr_done & gie_q;
   assign take_any  = take_call | take_ret | take_reti | take_irq;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (take_call || take_irq) state_d = ST_PUSH_HI;
            else if (take_ret)         state_d = ST_POP_LO;
            else if (take_reti)        state_d = ST_POP_STAT;
         end
         ST_PUSH_HI:   state_d = ST_PUSH_LO;
         ST_PUSH_LO:   state_d = framed_q ? ST_PUSH_STAT : ST_IDLE;
         ST_PUSH_STAT: state_d = ST_IDLE;
         ST_POP_STAT:  state_d = ST_POP_LO;
         ST_POP_LO:    state_d = ST_POP_HI;
         ST_POP_HI:    state_d = ST_POP_END;
         ST_POP_END:   state_d = ST_IDLE;
         default:      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         framed_q <= 1'b0;
         gie_q    <= GIE_RESET;
      end else begin
         state_q <= state_d;
         if (take_any) begin
            framed_q <= take_irq | take_reti;
         end
         if (take_irq) begin
            gie_q <= 1'b0;
         end else if (state_q == ST_POP_END && framed_q) begin
            gie_q <= 1'b1;
         end
      end
   end

   assign state  = state_q;
   assign framed = framed_q;
   assign gie    = gie_q;

endmodule

// File: rtl/stkseq_datapath.sv
module stkseq_datapath
   import stkseq_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned PC_W   = 16,
   parameter int unsigned ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  seq_state_t        state,
   input  logic              framed,
   input  logic              take_any,
   input  logic              take_irq,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [PC_W-1:0]   irq_vector,
   input  logic [PC_W-1:0]   call_target,
   input  logic [DATA_W-1:0] status_in,
   input  logic [ADDR_W-1:0] sp,
   input  logic [ADDR_W-1:0] sp_next_up,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              ram_we,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   output logic              pc_load,
   output logic [PC_W-1:0]   pc_out,
   output logic              status_load,
   output logic [DATA_W-1:0] status_out
);

   localparam int unsigned NBYTES = PC_W / DATA_W;

   logic [PC_W-1:0]   save_pc_q;
   logic [PC_W-1:0]   dest_q;
   logic [DATA_W-1:0] save_stat_q;
   logic [DATA_W-1:0] low_q;
   logic [DATA_W-1:0] pc_byte [NBYTES];

   for (genvar b = 0; b < NBYTES; b++) begin : g_split
      assign pc_byte[b] = save_pc_q[b*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         save_pc_q   <= '0;
         dest_q      <= '0;
         save_stat_q <= '0;
         low_q       <= '0;
      end else begin
         if (take_any) begin
            save_pc_q   <= pc_in;
            save_stat_q <= status_in;
            dest_q      <= take_irq ? irq_vector : call_target;
         end
         if (state == ST_POP_HI) begin
            low_q <= ram_rdata;
         end
      end
   end

   assign ram_we   = is_push(state);
   assign ram_re   = is_pop_read(state);
   assign ram_addr = ram_re ? sp_next_up : sp;

   always_comb begin
      unique case (state)
         ST_PUSH_HI:   ram_wdata = pc_byte[NBYTES-1];
         ST_PUSH_LO:   ram_wdata = pc_byte[0];
         ST_PUSH_STAT: ram_wdata = save_stat_q;
         default:      ram_wdata = '0;
      endcase
   end

   assign pc_load = ((state == ST_PUSH_LO) && !framed)
                  || (state == ST_PUSH_STAT)
                  || (state == ST_POP_END);
   assign pc_out  = (state == ST_POP_END) ? {ram_rdata, low_q} : dest_q;

   assign status_load = (state == ST_POP_LO) && framed;
   assign status_out  = ram_rdata;

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
   import stkseq_pkg::*;
#(
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned PC_W     = 16,
   parameter int unsigned ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] SP_RESET = 12'h8FF,
   parameter logic GIE_RESET       = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              instr_done,
   input  logic              irq_pending,
   input  logic [PC_W-1:0]   irq_vector,
   input  logic              call_req,
   input  logic [PC_W-1:0]   call_target,
   input  logic              ret_req,
   input  logic              reti_req,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [DATA_W-1:0] status_in,
   output logic              ram_we,
   output logic              ram_re,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [DATA_W-1:0] ram_wdata,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic              pc_load,
   output logic [PC_W-1:0]   pc_out,
   output logic              status_load,
   output logic [DATA_W-1:0] status_out,
   output logic              gie,
   output logic              busy
);

   if (PC_W != 2 * DATA_W) begin : g_bad_pc_w
      $error("irq_stack_seq: PC_W must span exactly two stack bytes");
   end
   if (ADDR_W < 4 || ADDR_W > 24) begin : g_bad_addr_w
      $error("irq_stack_seq: ADDR_W out of supported range");
   end

   seq_state_t        state;
   logic              framed, take_any, take_irq;
   logic [ADDR_W-1:0] sp, sp_next_up;

   stkseq_fsm #(.GIE_RESET(GIE_RESET)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .instr_done  (instr_done),
      .irq_pending (irq_pending),
      .call_req    (call_req),
      .ret_req     (ret_req),
      .reti_req    (reti_req),
      .state       (state),
      .framed      (framed),
      .take_any    (take_any),
      .take_irq    (take_irq),
      .gie         (gie)
   );

   stkseq_sp #(.ADDR_W(ADDR_W), .SP_RESET(SP_RESET)) u_sp (
      .clk        (clk),
      .rst_n      (rst_n),
      .dec        (is_push(state)),
      .inc        (is_pop_read(state)),
      .sp         (sp),
      .sp_next_up (sp_next_up)
   );

   stkseq_datapath #(.DATA_W(DATA_W), .PC_W(PC_W), .ADDR_W(ADDR_W)) u_dp (
      .clk         (clk),
      .rst_n       (rst_n),
      .state       (state),
      .framed      (framed),
      .take_any    (take_any),
      .take_irq    (take_irq),
      .pc_in       (pc_in),
      .irq_vector  (irq_vector),
      .call_target (call_target),
      .status_in   (status_in),
      .sp          (sp),
      .sp_next_up  (sp_next_up),
      .ram_rdata   (ram_rdata),
      .ram_we      (ram_we),
      .ram_re      (ram_re),
      .ram_addr    (ram_addr),
      .ram_wdata   (ram_wdata),
      .pc_load     (pc_load),
      .pc_out      (pc_out),
      .status_load (status_load),
      .status_out  (status_out)
   );

   assign busy = (state != ST_IDLE);

endmodule

// File: rtl/irq_stack_seq_chk.sv
module irq_stack_seq_chk #(
   parameter int unsigned ADDR_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              instr_done,
   input logic              irq_pending,
   input logic              call_req,
   input logic              ret_req,
   input logic              reti_req,
   input logic              ram_we,
   input logic              ram_re,
   input logic [ADDR_W-1:0] ram_addr,
   input logic              pc_load,
   input logic              status_load,
   input logic              gie,
   input logic              busy
);

   assert_call_starts_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && call_req) |=> (busy && ram_we));

   assert_irq_masks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && irq_pending && instr_done && gie && !call_req && !ret_req && !reti_req)
      |=> (!gie && ram_we));

   assert_masked_stays_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !gie && !call_req && !ret_req && !reti_req) |=> !busy);

   assert_push_descends_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we && $past(ram_we)) |-> (ram_addr == ADDR_W'($past(ram_addr) - 1'b1)));

   assert_pop_ascends_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_re && $past(ram_re)) |-> (ram_addr == ADDR_W'($past(ram_addr) + 1'b1)));

   assert_gie_after_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gie) |-> $past(pc_load));

   assert_single_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ram_we && ram_re));

   assert_status_in_seq_R6: assert property (@(posedge clk) disable iff (!rst_n)
      status_load |-> (busy && ram_re));

endmodule

bind irq_stack_seq irq_stack_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .instr_done  (instr_done),
   .irq_pending (irq_pending),
   .call_req    (call_req),
   .ret_req     (ret_req),
   .reti_req    (reti_req),
   .ram_we      (ram_we),
   .ram_re      (ram_re),
   .ram_addr    (ram_addr),
   .pc_load     (pc_load),
   .status_load (status_load),
   .gie         (gie),
   .busy        (busy)
);

// File: tb/test_irq_stack_seq.sv
module test_irq_stack_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        instr_done = 1'b0, irq_pending = 1'b0;
   logic [15:0] irq_vector = '0, call_target = '0, pc_in = '0;
   logic        call_req = 1'b0, ret_req = 1'b0, reti_req = 1'b0;
   logic [7:0]  status_in = '0;
   logic        ram_we, ram_re, pc_load, status_load, gie, busy;
   logic [11:0] ram_addr;
   logic [7:0]  ram_wdata, status_out;
   logic [7:0]  ram_rdata = '0;
   logic [15:0] pc_out;
   logic [7:0]  mem [0:4095];

   int checks = 0;
   int errors = 0;
   logic [11:0] exp_sp = 12'h8FF;

   always #2 clk = ~clk;

   irq_stack_seq i_irq_stack_seq (
      .clk(clk), .rst_n(rst_n), .instr_done(instr_done), .irq_pending(irq_pending),
      .irq_vector(irq_vector), .call_req(call_req), .call_target(call_target),
      .ret_req(ret_req), .reti_req(reti_req), .pc_in(pc_in), .status_in(status_in),
      .ram_we(ram_we), .ram_re(ram_re), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
      .ram_rdata(ram_rdata), .pc_load(pc_load), .pc_out(pc_out),
      .status_load(status_load), .status_out(status_out), .gie(gie), .busy(busy)
   );

   always @(posedge clk) begin
      if (ram_we) mem[ram_addr] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[ram_addr];
   end

   // pc_in / call_target pairs for nested calls
   localparam logic [31:0] CALLS [4] = '{
      {16'h1234, 16'h0400}, {16'hABCD, 16'h0520},
      {16'h00FF, 16'h0610}, {16'h8001, 16'h07FE}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_call(input logic [15:0] pc, input logic [15:0] tgt);
      call_req = 1'b1; pc_in = pc; call_target = tgt;
      step();
      call_req = 1'b0;
      chk("R2 hi write", {ram_we, 3'b0, ram_addr, ram_wdata}, {1'b1, 3'b0, exp_sp, pc[15:8]});
      step();
      chk("R2 lo write", {ram_we, 3'b0, ram_addr, ram_wdata}, {1'b1, 3'b0, exp_sp - 12'd1, pc[7:0]});
      chk("R2 jump", {pc_load, pc_out}, {1'b1, tgt});
      step();
      chk("R2 done", busy, 1'b0);
      exp_sp = exp_sp - 12'd2;
   endtask

   task automatic do_ret(input logic [15:0] exp_pc);
      ret_req = 1'b1;
      step();
      ret_req = 1'b0;
      chk("R3 read lo", {ram_re, 3'b0, ram_addr}, {1'b1, 3'b0, exp_sp + 12'd1});
      step();
      chk("R3 read hi", {ram_re, 3'b0, ram_addr}, {1'b1, 3'b0, exp_sp + 12'd2});
      step();
      chk("R3 jump back", {pc_load, pc_out}, {1'b1, exp_pc});
      step();
      chk("R3 done", busy, 1'b0);
      exp_sp = exp_sp + 12'd2;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", {busy, ram_we, ram_re, pc_load, status_load, gie}, 6'b000001);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 idle after reset", {busy, gie}, 2'b01);

      // R9 / R2: nested calls from the table, first push must land at 0x8FF (R1)
      for (int i = 0; i < 4; i++) do_call(CALLS[i][31:16], CALLS[i][15:0]);
      chk("R9 depth", {20'd0, exp_sp}, 32'h8F7);
      for (int i = 3; i >= 0; i--) do_ret(CALLS[i][31:16]);
      chk("R9 balanced", {20'd0, exp_sp}, 32'h8FF);

      // R4: no instruction boundary, no entry
      irq_pending = 1'b1; irq_vector = 16'h0026; pc_in = 16'h01A4; status_in = 8'h5A;
      step();
      chk("R4 waits for boundary", busy, 1'b0);

      // R5: entry
      instr_done = 1'b1;
      step();
      irq_pending = 1'b0; instr_done = 1'b0;
      chk("R5 gie cleared", gie, 1'b0);
      chk("R5 pc hi", {ram_we, 3'b0, ram_addr, ram_wdata}, {1'b1, 3'b0, exp_sp, 8'h01});
      step();
      chk("R5 pc lo", {ram_we, 3'b0, ram_addr, ram_wdata}, {1'b1, 3'b0, exp_sp - 12'd1, 8'hA4});
      step();
      chk("R5 status", {ram_we, 3'b0, ram_addr, ram_wdata}, {1'b1, 3'b0, exp_sp - 12'd2, 8'h5A});
      chk("R5 vector", {pc_load, pc_out}, {1'b1, 16'h0026});
      step();
      chk("R5 done", {busy, gie}, 2'b00);
      exp_sp = exp_sp - 12'd3;

      // R4: masked while gie is clear
      irq_pending = 1'b1; instr_done = 1'b1; irq_vector = 16'h0040;
      step();
      chk("R4 masked", {busy, ram_we}, 2'b00);
      irq_pending = 1'b0; instr_done = 1'b0;

      // R6: interrupt return
      reti_req = 1'b1;
      step();
      reti_req = 1'b0;
      chk("R6 read status", {ram_re, 3'b0, ram_addr}, {1'b1, 3'b0, exp_sp + 12'd1});
      step();
      chk("R6 status restore", {status_load, status_out}, {1'b1, 8'h5A});
      chk("R6 read lo", ram_addr, exp_sp + 12'd2);
      step();
      chk("R6 read hi", ram_addr, exp_sp + 12'd3);
      step();
      chk("R6 resume", {pc_load, pc_out}, {1'b1, 16'h01A4});
      step();
      chk("R6 gie restored", {busy, gie}, 2'b01);
      exp_sp = exp_sp + 12'd3;

      // R7: requests during a sequence are ignored
      call_req = 1'b1; pc_in = 16'h2468; call_target = 16'h0300;
      step();
      call_req = 1'b0; ret_req = 1'b1; irq_pending = 1'b1; instr_done = 1'b1;
      chk("R7 write at sp", ram_addr, exp_sp);
      step();
      chk("R7 no read mid push", {ram_we, ram_re}, 2'b10);
      ret_req = 1'b0; irq_pending = 1'b0; instr_done = 1'b0;
      step();
      chk("R7 ignored request", {busy, gie}, 2'b01);
      exp_sp = exp_sp - 12'd2;
      do_ret(16'h2468);

      // R8: call beats interrupt
      call_req = 1'b1; irq_pending = 1'b1; instr_done = 1'b1;
      pc_in = 16'h3C5A; call_target = 16'h0700; irq_vector = 16'h0026;
      step();
      call_req = 1'b0; irq_pending = 1'b0; instr_done = 1'b0;
      chk("R8 call wins", {gie, ram_wdata}, {1'b1, 8'h3C});
      step();
      chk("R8 call target", {pc_load, pc_out}, {1'b1, 16'h0700});
      step();
      exp_sp = exp_sp - 12'd2;

      // R8: return beats interrupt return
      ret_req = 1'b1; reti_req = 1'b1;
      step();
      ret_req = 1'b0; reti_req = 1'b0;
      chk("R8 ret addr", ram_addr, exp_sp + 12'd1);
      step();
      chk("R8 no status pop", status_load, 1'b0);
      step();
      chk("R8 ret value", {pc_load, pc_out}, {1'b1, 16'h3C5A});
      step();
      exp_sp = exp_sp + 12'd2;
      chk("R9 back to top", {busy, 3'b0, exp_sp}, {1'b0, 3'b0, 12'h8FF});

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule